// File: doc/BRIEF.md
# Receive Station Address Filter

This block holds a bank of exact-match destination addresses for an Ethernet receive path. Software loads each entry through a 32-bit register port as two words. The first word carries the first four address bytes. The second word carries the last two bytes and a valid flag. Writing the first word only stages it. The entry changes when the second word is written, so the hardware never compares against half an update.

When the frame parser presents a destination address with a one-cycle strobe, the block compares it with every valid entry at the same time. One cycle later it reports whether any entry matched and the index of the lowest-numbered matching entry. Entries read back through the same word map. Reset clears all entries. Software is expected to write the station's own address into entry 0 and leave the others at zero, which keeps them invalid.

Top module: `rx_station_filter`

## Requirements
- R1: Word address `2*k` is the low word of entry k and `2*k+1` is its high word. In the low word, wire-order byte 0 sits in bits 7:0, byte 1 in 15:8, byte 2 in 23:16 and byte 3 in 31:24. On `rx_da`, wire byte n occupies bits 8n+7:8n.
- R2: In the high word, byte 4 sits in bits 7:0, byte 5 in bits 15:8 and the entry-valid flag in bit 31. Bits 30:16 are dropped on write and read back as zero.
- R3: An entry becomes valid only when its high-word write has bit 31 set and the resulting 48-bit address is not all zeros. Otherwise the entry is left invalid.
- R4: A low-word write only stages data. The entry's address and its low-word readback stay unchanged until a high-word write to the same entry commits the staged word together with the high word.
- R5: A high-word write takes the staged low word only if the latest low-word write targeted the same entry and no high-word write has occurred since. Otherwise the entry keeps its current low word. Any high-word write consumes the staged word.
- R6: An entry whose valid flag is clear never matches, whatever address bits it holds.
- R7: `match_vld` is high exactly in the cycle after `rx_da_vld` was high. The `match_hit` and `match_idx` outputs are registered from the same compare, which uses the entry contents from before any write made in the strobe cycle.
- R8: When several valid entries match, `match_idx` gives the lowest-numbered one.
- R9: Reset clears every entry (entry 0 included), every valid flag, the staged word and all match outputs.
- R10: When no entry matches, or when no result is presented, `match_hit` and `match_idx` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | IDX_W+1 | Word address: entry index above, high/low select in bit 0 |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| rx_da_vld | input | 1 | Destination address strobe |
| rx_da | input | 48 | Destination address, wire byte n in bits 8n+7:8n |
| match_vld | output | 1 | Result valid, one cycle after the strobe |
| match_hit | output | 1 | Some valid entry matched |
| match_idx | output | IDX_W | Lowest matching entry index |

## Verification
Directed cases use a known address to check byte placement on both write and readback. They also check staging: a low-word write alone must not change the entry or its matching, and a high-word write to a different entry must not take the staged word. Duplicate addresses in two entries separate lowest-index priority from any other order. Zero-address and flag-clear writes show that the valid rule gates matching. A random phase draws writes and strobes from a small pool of addresses. This makes repeated hits, same-cycle write-and-compare, and staging across interleaved entries frequent, and a behavioural model checks every output on each clock.

// File: rtl/rx_station_filter.sv
module rx_station_filter #(
  parameter int NUM_ENTRIES = 16,
  localparam int IDX_W  = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
  localparam int ADDR_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              rx_da_vld,
  input  logic [47:0]       rx_da,
  output logic              match_vld,
  output logic              match_hit,
  output logic [IDX_W-1:0]  match_idx
);

  logic [47:0]            ent_addr [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] ent_vld;
  logic [31:0]            stg_lo;
  logic [IDX_W-1:0]       stg_idx;
  logic                   stg_ok;

  wire [IDX_W-1:0] sel_idx  = reg_addr[ADDR_W-1:1];
  wire             sel_hi   = reg_addr[0];
  wire             in_range = {1'b0, sel_idx} < (IDX_W+1)'(NUM_ENTRIES);

  logic [31:0] commit_lo;
  logic [47:0] new_addr;
  logic        new_vld;

  always_comb begin
    commit_lo = 32'h0;
    if (in_range)
      commit_lo = (stg_ok && stg_idx == sel_idx) ? stg_lo : ent_addr[sel_idx][31:0];
    new_addr = {reg_wdata[15:0], commit_lo};
    new_vld  = reg_wdata[31] && (new_addr != 48'h0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ENTRIES; i++) ent_addr[i] <= '0;
      ent_vld <= '0;
      stg_lo  <= '0;
      stg_idx <= '0;
      stg_ok  <= 1'b0;
    end else if (reg_wr && in_range) begin
      if (!sel_hi) begin
        stg_lo  <= reg_wdata;
        stg_idx <= sel_idx;
        stg_ok  <= 1'b1;
      end else begin
        ent_addr[sel_idx] <= new_addr;
        ent_vld[sel_idx]  <= new_vld;
        stg_ok            <= 1'b0;
      end
    end
  end

  always_comb begin
    reg_rdata = 32'h0;
    if (in_range)
      reg_rdata = sel_hi ? {ent_vld[sel_idx], 15'h0, ent_addr[sel_idx][47:32]}
                         : ent_addr[sel_idx][31:0];
  end

  logic [NUM_ENTRIES-1:0] eq;
  logic [IDX_W-1:0]       first_idx;

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
    assign eq[g] = ent_vld[g] && (ent_addr[g] == rx_da);

    assert_valid_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ent_vld[g] |-> (ent_addr[g] != 48'h0));
    assert_low_write_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && !reg_addr[0]) |=> $stable(ent_addr[g]) && $stable(ent_vld[g]));
  end

  always_comb begin
    first_idx = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--)
      if (eq[i]) first_idx = IDX_W'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_vld <= 1'b0;
      match_hit <= 1'b0;
      match_idx <= '0;
    end else begin
      match_vld <= rx_da_vld;
      match_hit <= rx_da_vld && (|eq);
      match_idx <= (rx_da_vld && (|eq)) ? first_idx : '0;
    end
  end

  assert_result_follows_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_da_vld |=> match_vld);
  assert_quiet_without_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_da_vld |=> !match_vld && !match_hit);
  assert_idx_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    match_hit |-> ({1'b0, match_idx} < (IDX_W+1)'(NUM_ENTRIES)));
  assert_miss_idx_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !match_hit |-> (match_idx == '0));

endmodule

// File: tb/rx_station_filter_bench.sv
module rx_station_filter_bench;
  localparam int N      = 16;
  localparam int IDX_W  = $clog2(N);
  localparam int ADDR_W = IDX_W + 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reg_wr = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [31:0]       reg_wdata = '0;
  logic [31:0]       reg_rdata;
  logic              rx_da_vld = 1'b0;
  logic [47:0]       rx_da = '0;
  logic              match_vld, match_hit;
  logic [IDX_W-1:0]  match_idx;

  int tests = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rx_station_filter #(.NUM_ENTRIES(N)) u_rx_station_filter (
    .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
    .rx_da_vld, .rx_da, .match_vld, .match_hit, .match_idx);

  // behavioural reference
  logic [47:0] m_addr [N];
  bit          m_vld  [N];
  logic [31:0] m_stg;
  int          m_stg_idx;
  bit          m_stg_ok;
  bit          e_vld, e_hit;
  int          e_idx;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin m_addr[i] = '0; m_vld[i] = 0; end
      m_stg = '0; m_stg_idx = 0; m_stg_ok = 0;
      e_vld = 0; e_hit = 0; e_idx = 0;
    end else begin
      e_vld = rx_da_vld; e_hit = 0; e_idx = 0;
      if (rx_da_vld)
        for (int i = 0; i < N; i++)
          if (!e_hit && m_vld[i] && m_addr[i] == rx_da) begin e_hit = 1; e_idx = i; end
      if (reg_wr) begin
        int k;
        k = int'(reg_addr) / 2;
        if (reg_addr % 2 == 0) begin
          m_stg = reg_wdata; m_stg_idx = k; m_stg_ok = 1;
        end else begin
          logic [31:0] lo;
          lo = (m_stg_ok && m_stg_idx == k) ? m_stg : m_addr[k][31:0];
          m_addr[k] = {reg_wdata[15:0], lo};
          m_vld[k]  = reg_wdata[31] && (m_addr[k] != 0);
          m_stg_ok  = 0;
        end
      end
    end
  end

  function automatic logic [31:0] m_read(int a);
    int k = a / 2;
    if (a % 2 == 1) return {m_vld[k] ? 1'b1 : 1'b0, 15'h0, m_addr[k][47:32]};
    return m_addr[k][31:0];
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk(match_vld == e_vld, "R7 match_vld vs model", 64'(match_vld), 64'(e_vld));
    chk(match_hit == e_hit, "R6 match_hit vs model", 64'(match_hit), 64'(e_hit));
    chk(int'(match_idx) == e_idx, "R8 match_idx vs model", 64'(match_idx), 64'(e_idx));
    chk(reg_rdata == m_read(int'(reg_addr)), "R1 reg_rdata vs model",
        64'(reg_rdata), 64'(m_read(int'(reg_addr))));
  end

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk); #1 reg_wr = 1; reg_addr = ADDR_W'(a); reg_wdata = d;
    @(negedge clk); #1 reg_wr = 0;
  endtask

  task automatic rd_chk(int a, logic [31:0] exp, string tag);
    @(negedge clk); #1 reg_addr = ADDR_W'(a); #1;
    chk(reg_rdata == exp, tag, 64'(reg_rdata), 64'(exp));
  endtask

  task automatic look(logic [47:0] da, bit hit, int idx, string tag);
    @(negedge clk); #1 rx_da_vld = 1; rx_da = da;
    @(negedge clk); #1 rx_da_vld = 0;
    chk(match_vld && match_hit == hit && int'(match_idx) == idx, tag,
        {match_vld, match_hit, 8'(match_idx)}, {1'b1, hit, 8'(idx)});
  endtask

  task automatic finish_up();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    fails++; tests++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  localparam logic [47:0] A0 = 48'h5634_1200_AA01; // wire 01 AA 00 12 34 56
  localparam logic [47:0] A1 = 48'h0B0A_0D0C_0E0F;

  initial begin
    logic [47:0] pool [5];
    #3;
    chk(match_vld == 0 && match_hit == 0 && match_idx == 0 && reg_rdata == 0,
        "R9 outputs in reset", {match_vld, match_hit, 8'(match_idx), reg_rdata}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int a = 0; a < 2 * N; a++) rd_chk(a, 32'h0, "R9 entries clear after reset");

    // R1 R2: byte placement, unused high bits dropped
    wr(0, 32'h1200_AA01);
    wr(1, 32'hFFFF_5634);
    rd_chk(0, 32'h1200_AA01, "R1 low word layout");
    rd_chk(1, 32'h8000_5634, "R2 high word layout and valid");
    look(A0, 1, 0, "R7 hit on entry 0");

    // R4: staged low word has no effect until high write
    wr(6, A1[31:0]);
    rd_chk(6, 32'h0, "R4 low readback unchanged before commit");
    look(48'h0000_0D0C_0E0F, 0, 0, "R4 no match on staged only");
    wr(7, {16'h8000, A1[47:32]});
    rd_chk(6, A1[31:0], "R4 low committed by high write");
    look(A1, 1, 3, "R4 match after commit");

    // R5: staged low for entry 5 not taken by a high write to entry 6
    wr(10, 32'hDEAD_BEEF);
    wr(13, 32'h8000_0077);
    rd_chk(12, 32'h0, "R5 other entry keeps its low word");
    rd_chk(13, 32'h8000_0077, "R5 high committed with valid");
    wr(11, 32'h8000_0001);
    rd_chk(10, 32'h0, "R5 staged word consumed by earlier high write");

    // R3 R6: zero address or clear flag gives invalid entry
    wr(8, 32'h0); wr(9, 32'h8000_0000);
    rd_chk(9, 32'h0, "R3 zero address stays invalid");
    wr(8, A0[31:0]); wr(9, {16'h0, A0[47:32]});
    rd_chk(9, {16'h0, A0[47:32]}, "R3 flag clear stays invalid");
    wr(0, A0[31:0]); wr(1, {16'h0, A0[47:32]});
    look(A0, 0, 0, "R6 invalid entries never match");

    // R8: duplicates, lowest index wins
    wr(4, A0[31:0]); wr(5, {16'h8000, A0[47:32]});
    wr(14, A0[31:0]); wr(15, {16'h8000, A0[47:32]});
    look(A0, 1, 2, "R8 lowest of entries 2 and 7");
    wr(5, {16'h0, A0[47:32]});
    look(A0, 1, 7, "R8 next entry after invalidation");
    look(48'h1111_2222_3333, 0, 0, "R10 miss gives idx zero");

    // random phase
    pool[0] = A0; pool[1] = A1; pool[2] = 48'h0000_0000_0001;
    pool[3] = 48'h0; pool[4] = 48'hFFFF_FFFF_FFFF;
    for (int c = 0; c < 4000; c++) begin
      int p;
      p = $urandom % 5;
      @(negedge clk); #1;
      reg_wr   = ($urandom % 3) == 0;
      reg_addr = ADDR_W'($urandom);
      reg_wdata = reg_addr[0] ? {1'($urandom), 15'($urandom), pool[p][47:32]} : pool[p][31:0];
      rx_da_vld = ($urandom % 2) == 0;
      rx_da = pool[$urandom % 5];
    end
    @(negedge clk); #1 reg_wr = 0; rx_da_vld = 0;

    // R9: reset mid-run clears everything
    wr(0, A0[31:0]); wr(1, {16'h8000, A0[47:32]});
    @(negedge clk); #1 rst_n = 0; #1;
    chk(reg_rdata == 0 && match_vld == 0, "R9 reset clears entry 0",
        {reg_rdata, 8'(match_vld)}, 0);
    @(negedge clk); #1 rst_n = 1;
    look(A0, 0, 0, "R9 no match after reset");
    finish_up();
  end
endmodule